// File: doc/BRIEF.md
# Multiply-Accumulate Arithmetic Datapath

This block is the arithmetic core of a small cryptographic engine that works on long integers sixteen bits at a time. A microcode sequencer presents one operation code per clock along with two 16-bit operands read from a dual-port memory. The block either multiplies the operands and adds the 32-bit product to a wide accumulator in that same cycle, or adds or subtracts one operand, or shifts the accumulator down one word, or runs a bitwise logic operation for hash rounds.

The accumulator is 40 bits wide. The eight bits above the 32-bit product width are guard bits. They let a long column of partial products in a multi-precision multiplication build up without losing a carry. A right shift by one word then hands the column carry on to the next column. The block can also act as a plain 16-bit holding register, and it can pick one bit out of an operand so that the sequencer can scan the bits of a scalar. A 16-bit slice of the accumulator, either the low word or the next word up, is always presented for write-back.

Top module: `mac_datapath`

## Requirements
- R1: While `rst_n` is low the accumulator is zero, so `res_o` reads 0x0000 for either slice. The reset is asynchronous.
- R2: Operation code 2 (MAC) sets acc to acc + a*b at the next rising clock. The product is unsigned 16x16, and the sum wraps modulo 2^40.
- R3: Starting from zero, 256 MAC operations of 0xFFFF*0xFFFF give exactly 0xFF_FE00_0100, so no carry is lost.
- R4: Operation code 3 (ADD) sets acc to acc + a, and code 4 (SUB) sets acc to acc - a. In both cases a is zero-extended and the result wraps modulo 2^40.
- R5: Operation code 5 (SHR) shifts the accumulator right by 16 and fills the top with zeros.
- R6: Operation codes 6 (AND), 7 (OR) and 8 (XOR) write a op b into acc[15:0] and clear acc[39:16].
- R7: Operation code 9 (LOAD) sets acc to zero-extended a.
- R8: Operation code 10 (BITX) sets acc[0] to bit `bit_sel_i` of a and clears acc[39:1].
- R9: Operation code 1 (CLR) clears the accumulator. Code 0 (NOP) and the unused codes 11 to 15 leave it unchanged.
- R10: `res_o` shows acc[31:16] when `slice_hi_i` is 1 and acc[15:0] when it is 0. It follows `slice_hi_i` with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| bit_sel_i | input | 4 | Bit index used by BITX |
| slice_hi_i | input | 1 | Slice select: 1 for bits 31:16, 0 for bits 15:0 |
| res_o | output | 16 | Selected accumulator slice |

## Verification
Every operation updates the accumulator at the rising edge that samples its operation code. Its result therefore shows on `res_o` one cycle after the stimulus. The slice select and reset act on `res_o` within the same cycle. The bench drives inputs at the falling edge and reads `res_o` at the following falling edge, which is half a period after the edge that made the update. For the slice select it reads within the same low phase. The 256-step guard-bit run is checked only after its last operation, and then again after two shifts so that the guard byte is read as well.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_NOP  = 4'd0,
    OP_CLR  = 4'd1,
    OP_MAC  = 4'd2,
    OP_ADD  = 4'd3,
    OP_SUB  = 4'd4,
    OP_SHR  = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8,
    OP_LOAD = 4'd9,
    OP_BITX = 4'd10
  } op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logic_e;
endpackage

// File: rtl/mac_mul.sv
module mac_mul #(
  parameter int DW = 16
) (
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  output logic [2*DW-1:0] prod_o
);
  function automatic logic [2*DW-1:0] f_umul(input logic [DW-1:0] x, input logic [DW-1:0] y);
    logic [2*DW-1:0] xe;
    logic [2*DW-1:0] ye;
    xe = {{DW{1'b0}}, x};
    ye = {{DW{1'b0}}, y};
    return xe * ye;
  endfunction

  assign prod_o = f_umul(a_i, b_i);
endmodule

// File: rtl/mac_addsub.sv
module mac_addsub #(
  parameter int DW = 16,
  parameter int AW = 40
) (
  input  logic [AW-1:0]   acc_i,
  input  logic [2*DW-1:0] prod_i,
  input  logic [DW-1:0]   a_i,
  input  logic            sub_i,
  output logic [AW-1:0]   mac_sum_o,
  output logic [AW-1:0]   as_sum_o
);
  localparam int PGUARD = AW - 2*DW;
  localparam int AGUARD = AW - DW;

  function automatic logic [AW-1:0] f_add(input logic [AW-1:0] x, input logic [AW-1:0] y,
                                          input logic cin);
    return x + y + {{(AW-1){1'b0}}, cin};
  endfunction

  logic [AW-1:0] prod_ext;
  logic [AW-1:0] a_ext;
  logic [AW-1:0] a_opnd;

  assign prod_ext = {{PGUARD{1'b0}}, prod_i};
  assign a_ext    = {{AGUARD{1'b0}}, a_i};
  assign a_opnd   = sub_i ? ~a_ext : a_ext;

  // First adder: product into accumulator.
  assign mac_sum_o = f_add(acc_i, prod_ext, 1'b0);
  // Second adder: single operand add or two's complement subtract.
  assign as_sum_o  = f_add(acc_i, a_opnd, sub_i);
endmodule

// File: rtl/mac_logic.sv
module mac_logic #(
  parameter int DW = 16
) (
  input  mac_pkg::logic_e  fn_i,
  input  logic [DW-1:0]    a_i,
  input  logic [DW-1:0]    b_i,
  input  logic [$clog2(DW)-1:0] sel_i,
  output logic [DW-1:0]    lg_o,
  output logic             bit_o
);
  import mac_pkg::*;

  function automatic logic [DW-1:0] f_logic(input logic_e fn, input logic [DW-1:0] x,
                                            input logic [DW-1:0] y);
    case (fn)
      LG_AND:  return x & y;
      LG_OR:   return x | y;
      default: return x ^ y;
    endcase
  endfunction

  logic [DW-1:0] onehot;

  for (genvar g = 0; g < DW; g++) begin : g_dec
    assign onehot[g] = (sel_i == g[$clog2(DW)-1:0]);
  end

  assign lg_o  = f_logic(fn_i, a_i, b_i);
  assign bit_o = |(a_i & onehot);
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath #(
  parameter int DW = 16,
  parameter int AW = 40
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [3:0]             op_i,
  input  logic [DW-1:0]          a_i,
  input  logic [DW-1:0]          b_i,
  input  logic [$clog2(DW)-1:0]  bit_sel_i,
  input  logic                   slice_hi_i,
  output logic [DW-1:0]          res_o
);
  import mac_pkg::*;

  localparam int SELW = $clog2(DW);
  localparam int HIW  = AW - DW;

  op_e             op;
  logic [AW-1:0]   acc_q;
  logic [AW-1:0]   acc_d;
  logic [2*DW-1:0] prod;
  logic [AW-1:0]   mac_sum;
  logic [AW-1:0]   as_sum;
  logic [DW-1:0]   lg_val;
  logic            bit_val;
  logic_e          lg_fn;

  // Named events for the checker.
  logic ev_logic;
  logic ev_hold;

  assign op = op_e'(op_i);
  assign ev_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  assign ev_hold  = (op_i == 4'd0) || (op_i > 4'd10);

  always_comb begin
    case (op)
      OP_OR:   lg_fn = LG_OR;
      OP_XOR:  lg_fn = LG_XOR;
      default: lg_fn = LG_AND;
    endcase
  end

  mac_mul #(.DW(DW)) u_mul (
    .a_i    (a_i),
    .b_i    (b_i),
    .prod_o (prod)
  );

  mac_addsub #(.DW(DW), .AW(AW)) u_addsub (
    .acc_i     (acc_q),
    .prod_i    (prod),
    .a_i       (a_i),
    .sub_i     (op == OP_SUB),
    .mac_sum_o (mac_sum),
    .as_sum_o  (as_sum)
  );

  mac_logic #(.DW(DW)) u_logic (
    .fn_i  (lg_fn),
    .a_i   (a_i),
    .b_i   (b_i),
    .sel_i (bit_sel_i),
    .lg_o  (lg_val),
    .bit_o (bit_val)
  );

  always_comb begin
    case (op)
      OP_CLR:               acc_d = '0;
      OP_MAC:               acc_d = mac_sum;
      OP_ADD, OP_SUB:       acc_d = as_sum;
      OP_SHR:               acc_d = {{DW{1'b0}}, acc_q[AW-1:DW]};
      OP_AND, OP_OR, OP_XOR: acc_d = {{HIW{1'b0}}, lg_val};
      OP_LOAD:              acc_d = {{HIW{1'b0}}, a_i};
      OP_BITX:              acc_d = {{(AW-1){1'b0}}, bit_val};
      default:              acc_d = acc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign res_o = slice_hi_i ? acc_q[2*DW-1:DW] : acc_q[DW-1:0];

  logic [SELW-1:0] unused_sel;
  assign unused_sel = bit_sel_i;
endmodule

// File: rtl/mac_datapath_chk.sv
module mac_datapath_chk #(
  parameter int DW = 16,
  parameter int AW = 40
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    op_i,
  input logic [DW-1:0] a_i,
  input logic [DW-1:0] b_i,
  input logic [AW-1:0] acc_q,
  input logic          ev_logic,
  input logic          ev_hold
);
  logic [2*DW-1:0] prod_w;
  logic [AW-1:0]   prod_ext;
  assign prod_w   = {{DW{1'b0}}, a_i} * {{DW{1'b0}}, b_i};
  assign prod_ext = {{(AW-2*DW){1'b0}}, prod_w};

  // R1: accumulator is zero right after reset is released
  p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> acc_q == '0);

  // R2: MAC adds the product of the previous operands
  p_mac_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == 4'd2 |=> acc_q == $past(acc_q) + $past(prod_ext));

  // R5: shift moves one word down with zero fill
  p_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == 4'd5 |=> acc_q == ($past(acc_q) >> DW));

  // R6: logic results leave upper bits clear
  p_logic_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_logic |=> acc_q[AW-1:DW] == '0);

  // R8: bit extract leaves at most bit 0 set
  p_bitx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == 4'd10 |=> acc_q[AW-1:1] == '0);

  // R9: clear empties the accumulator
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == 4'd1 |=> acc_q == '0);

  // R9: hold codes keep the accumulator
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hold |=> $stable(acc_q));
endmodule

bind mac_datapath mac_datapath_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_i     (op_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .acc_q    (acc_q),
  .ev_logic (ev_logic),
  .ev_hold  (ev_hold)
);

// File: tb/mac_datapath_tb.sv
module mac_datapath_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 21;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [15:0] a = '0;
  logic [15:0] b = '0;
  logic [3:0]  sel = '0;
  logic        hi = 1'b0;
  logic [15:0] res;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  mac_datapath u_dut (
    .clk(clk), .rst_n(rst_n), .op_i(op), .a_i(a), .b_i(b),
    .bit_sel_i(sel), .slice_hi_i(hi), .res_o(res)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {op, a, b, sel, hi, expected res} ; expectations follow the requirements
  localparam logic [56:0] VEC [NV] = '{
    {4'd1,  16'h0000, 16'h0000, 4'd0,  1'b0, 16'h0000},
    {4'd2,  16'h1234, 16'h5678, 4'd0,  1'b0, 16'h0060},
    {4'd0,  16'h0000, 16'h0000, 4'd0,  1'b1, 16'h0626},
    {4'd2,  16'hFFFF, 16'hFFFF, 4'd0,  1'b1, 16'h0624},
    {4'd5,  16'h0000, 16'h0000, 4'd0,  1'b1, 16'h0001},
    {4'd3,  16'hFFFF, 16'h0000, 4'd0,  1'b0, 16'h0623},
    {4'd4,  16'h0624, 16'h0000, 4'd0,  1'b1, 16'h0001},
    {4'd4,  16'hFFFF, 16'h0000, 4'd0,  1'b0, 16'h0000},
    {4'd1,  16'h0000, 16'h0000, 4'd0,  1'b1, 16'h0000},
    {4'd4,  16'h0001, 16'h0000, 4'd0,  1'b1, 16'hFFFF},
    {4'd5,  16'h0000, 16'h0000, 4'd0,  1'b1, 16'h00FF},
    {4'd6,  16'hF0F0, 16'h3C3C, 4'd0,  1'b0, 16'h3030},
    {4'd0,  16'h0000, 16'h0000, 4'd0,  1'b1, 16'h0000},
    {4'd7,  16'hF0F0, 16'h0F0F, 4'd0,  1'b0, 16'hFFFF},
    {4'd8,  16'hFF00, 16'h0FF0, 4'd0,  1'b0, 16'hF0F0},
    {4'd9,  16'hBEEF, 16'h0000, 4'd0,  1'b0, 16'hBEEF},
    {4'd0,  16'h0000, 16'h0000, 4'd0,  1'b1, 16'h0000},
    {4'd10, 16'h8000, 16'h0000, 4'd15, 1'b0, 16'h0001},
    {4'd10, 16'h8000, 16'h0000, 4'd14, 1'b0, 16'h0000},
    {4'd9,  16'h1234, 16'h0000, 4'd0,  1'b0, 16'h1234},
    {4'd15, 16'hAAAA, 16'h5555, 4'd3,  1'b0, 16'h1234}
  };

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd1:        return "R9 clear";
      4'd2:        return "R2 mac";
      4'd3, 4'd4:  return "R4 add/sub";
      4'd5:        return "R5 shift";
      4'd6, 4'd7, 4'd8: return "R6 logic";
      4'd9:        return "R7 load";
      4'd10:       return "R8 bitx";
      default:     return "R9 hold / R10 slice";
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] exp);
    n_chk++;
    if (res !== exp) begin
      n_fail++;
      $display("FAIL %s: res_o=%h expected=%h", tag, res, exp);
    end
  endtask

  // Drive at a falling edge, result due after the next rising edge.
  task automatic run_op(input logic [3:0] o, input logic [15:0] x, input logic [15:0] y,
                        input logic [3:0] s, input logic h);
    op = o; a = x; b = y; sel = s; hi = h;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    hi = 1'b0; check("R1 reset lo", 16'h0000);
    hi = 1'b1; #1; check("R1 reset hi", 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][56:53], VEC[i][52:37], VEC[i][36:21], VEC[i][20:17], VEC[i][16]);
      check(tag_of(VEC[i][56:53]), VEC[i][15:0]);
    end

    // R10: slice follows select with no clock
    run_op(4'd9, 16'hC0DE, 16'h0, 4'd0, 1'b0);
    run_op(4'd2, 16'h0100, 16'h0100, 4'd0, 1'b0); // acc = 0x1_C0DE
    op = 4'd0; hi = 1'b1; #1; check("R10 hi slice", 16'h0001);
    hi = 1'b0; #1; check("R10 lo slice", 16'hC0DE);

    // R3: guard bits absorb 256 maximal products
    run_op(4'd1, 16'h0, 16'h0, 4'd0, 1'b0);
    for (int k = 0; k < 256; k++) run_op(4'd2, 16'hFFFF, 16'hFFFF, 4'd0, 1'b0);
    op = 4'd0; #1; check("R3 guard lo", 16'h0100);
    hi = 1'b1; #1; check("R3 guard hi", 16'hFE00);
    run_op(4'd5, 16'h0, 16'h0, 4'd0, 1'b1);
    run_op(4'd5, 16'h0, 16'h0, 4'd0, 1'b0);
    check("R3 guard top", 16'h00FF);

    // R2: wrap modulo 2^40 - start at all ones, add product 1
    run_op(4'd1, 16'h0, 16'h0, 4'd0, 1'b0);
    run_op(4'd4, 16'h0001, 16'h0, 4'd0, 1'b0);
    run_op(4'd2, 16'h0001, 16'h0001, 4'd0, 1'b1);
    check("R2 wrap hi", 16'h0000);

    // R1: asynchronous reset mid-run
    run_op(4'd9, 16'h7777, 16'h0, 4'd0, 1'b0);
    op = 4'd0; #2; rst_n = 1'b0; #1;
    check("R1 async reset", 16'h0000);
    @(negedge clk); rst_n = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule